// File: doc/BRIEF.md
# Write-Back Rate Attack Detector

This block watches the stream of dirty-line evictions that a DRAM cache sends to a phase-change main memory. It splits the memory into a fixed number of regions and judges each region separately. A region that appears to be under a deliberate wear attack gets a one-cycle remap request. A separate remapping engine, outside this block, acts on that request.

Two families of judgement are available. In the cumulative mode, a region's write-back count is compared against an absolute limit. In the adaptive modes, the detector measures the share of a region's accesses that turn into write-backs over a measurement window, and compares that share with a programmable percentage. The window is either a fixed number of accesses to the region or the interval between two operating-system time-slice pulses. Normal programs also cause write-backs, and a sustained high rate is a better sign of an attack than a large raw count, so the adaptive modes avoid needless remaps.

Top module: `wb_attack_detector`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `remap_req` is all zeros.
- R2: When `mode` is 0 or 3 (cumulative), a write-back to region r that brings the region's write-back count to a value greater than or equal to `cum_thresh` sets bit r of `remap_req` on the next cycle.
- R3: When `mode` is 1 (access-window), region r's window closes on the access that brings its access count to PERIOD_LEN. At that point the region fires if writebacks*100 >= accesses*pct, with both counts including that cycle's events. The pulse appears on the next cycle.
- R4: When `mode` is 2 (time-slice), a `slice_end` pulse closes the window of every region at once, and each region is judged by the R3 rule. In mode 1, `slice_end` has no effect.
- R5: A region whose closing window holds zero accesses never fires, whatever its write-back count.
- R6: The effective percentage is `rate_pct` clamped to the range 20..100. Values below 20 act as 20 and values above 100 act as 100.
- R7: Each request is a single-cycle pulse. The firing region's access and write-back counts return to zero, so later events count from one.
- R8: Access and write-back counts saturate at 2^CNT_W-1 and never wrap.
- R9: An access event and a write-back event in the same cycle are both counted, whether they target the same region or different regions.
- R10: In the adaptive modes, both counts of a region clear at the close of its window, whether or not it fired.
- R11: Regions are independent. Events to one region never change another region's counts or requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | 0/3 cumulative, 1 access-window, 2 time-slice |
| cum_thresh | input | CNT_W | Absolute write-back limit for cumulative mode |
| rate_pct | input | 7 | Write-back rate threshold in percent (clamped 20..100) |
| acc_vld | input | 1 | A memory access occurred this cycle |
| acc_rid | input | RID_W | Region of that access |
| wb_vld | input | 1 | A cache write-back occurred this cycle |
| wb_rid | input | RID_W | Region of that write-back |
| slice_end | input | 1 | Time-slice boundary pulse |
| remap_req | output | NREG | Per-region one-cycle remap request |

## Verification
The hardest state to reach from the ports is a saturated counter. It needs hundreds of events with no window closing and no request firing, and only a time-slice close reveals it. The stimulus therefore runs time-slice mode at a 100% threshold, feeding equal access and write-back streams until both counts pin at the maximum, then extra write-backs. A wrapped write-back count would then fall below the access count and suppress the expected pulse. Clamp boundaries are reached by choosing access-to-write-back ratios that land between the raw and the clamped percentage.

// File: rtl/wbad_pkg.sv
package wbad_pkg;

  typedef enum logic [1:0] {
    MD_CUM     = 2'd0,
    MD_WINDOW  = 2'd1,
    MD_SLICE   = 2'd2,
    MD_CUM_ALT = 2'd3
  } wbad_mode_e;

  localparam logic [6:0] PCT_FLOOR = 7'd20;
  localparam logic [6:0] PCT_CEIL  = 7'd100;

  // Limit a programmed percentage to the supported band.
  function automatic logic [6:0] clamp_pct(input logic [6:0] raw);
    if (raw < PCT_FLOOR)      return PCT_FLOOR;
    else if (raw > PCT_CEIL)  return PCT_CEIL;
    else                      return raw;
  endfunction

  // Rate test without division: wb/acc >= pct/100.
  function automatic logic rate_hit(input logic [31:0] wb,
                                    input logic [31:0] acc,
                                    input logic [6:0]  pct);
    logic [63:0] lhs;
    logic [63:0] rhs;
    lhs = 64'(wb) * 64'd100;
    rhs = 64'(acc) * 64'(pct);
    return lhs >= rhs;
  endfunction

endpackage

// File: rtl/wbad_pct_clamp.sv
module wbad_pct_clamp
  import wbad_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [6:0] pct_raw,
  output logic [6:0] pct_eff
);

  assign pct_eff = clamp_pct(pct_raw);

  p_pct_band_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pct_eff >= 7'd20) && (pct_eff <= 7'd100));

  p_pct_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pct_raw >= 7'd20 && pct_raw <= 7'd100) |-> (pct_eff == pct_raw));

endmodule

// File: rtl/wbad_region.sv
module wbad_region
  import wbad_pkg::*;
#(
  parameter int CNT_W      = 8,
  parameter int PERIOD_LEN = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  wbad_mode_e       mode,
  input  logic             acc_hit,
  input  logic             wb_hit,
  input  logic             slice_end,
  input  logic [CNT_W-1:0] cum_thr,
  input  logic [6:0]       pct,
  output logic             remap_o
);

  localparam logic [CNT_W-1:0] CMAX    = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] WIN_LEN = CNT_W'(PERIOD_LEN);

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v,
                                               input logic en);
    if (en && v != CMAX) return v + 1'b1;
    else                 return v;
  endfunction

  logic [CNT_W-1:0] acc_cnt, wb_cnt;
  logic [CNT_W-1:0] acc_n, wb_n;
  logic             remap_q;

  // Named internal events
  logic cum_mode, win_close, slice_close, eval_adapt;
  logic cum_fire, adapt_fire, fire;

  assign acc_n       = sat_inc(acc_cnt, acc_hit);
  assign wb_n        = sat_inc(wb_cnt, wb_hit);

  assign cum_mode    = (mode == MD_CUM) || (mode == MD_CUM_ALT);
  assign win_close   = (mode == MD_WINDOW) && acc_hit && (acc_n >= WIN_LEN);
  assign slice_close = (mode == MD_SLICE) && slice_end;
  assign eval_adapt  = win_close || slice_close;

  assign cum_fire    = cum_mode && wb_hit && (wb_n >= cum_thr);
  assign adapt_fire  = eval_adapt && (acc_n != '0) &&
                       rate_hit(32'(wb_n), 32'(acc_n), pct);
  assign fire        = cum_fire || adapt_fire;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_cnt <= '0;
      wb_cnt  <= '0;
      remap_q <= 1'b0;
    end else begin
      remap_q <= fire;
      if (fire || eval_adapt) begin
        acc_cnt <= '0;
        wb_cnt  <= '0;
      end else begin
        acc_cnt <= acc_n;
        wb_cnt  <= wb_n;
      end
    end
  end

  assign remap_o = remap_q;

  p_cum_ge_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cum_mode && wb_hit && (wb_n >= cum_thr)) |=> remap_q);

  p_zero_acc_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_adapt && acc_n == '0 && !cum_mode) |=> !remap_q);

  p_pulse_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    remap_q |-> (acc_cnt == '0 && wb_cnt == '0));

  p_no_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_cnt == CMAX) |=> (wb_cnt == CMAX || wb_cnt == '0));

  p_acc_no_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_cnt == CMAX) |=> (acc_cnt == CMAX || acc_cnt == '0));

  p_window_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    eval_adapt |=> (acc_cnt == '0 && wb_cnt == '0));

endmodule

// File: rtl/wb_attack_detector.sv
module wb_attack_detector
  import wbad_pkg::*;
#(
  parameter int NREG       = 4,
  parameter int CNT_W      = 8,
  parameter int PERIOD_LEN = 16,
  localparam int RID_W     = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode,
  input  logic [CNT_W-1:0] cum_thresh,
  input  logic [6:0]       rate_pct,
  input  logic             acc_vld,
  input  logic [RID_W-1:0] acc_rid,
  input  logic             wb_vld,
  input  logic [RID_W-1:0] wb_rid,
  input  logic             slice_end,
  output logic [NREG-1:0]  remap_req
);

  wbad_mode_e       mode_e;
  logic [6:0]       pct_eff;
  logic [NREG-1:0]  acc_sel, wb_sel;

  assign mode_e = wbad_mode_e'(mode);

  wbad_pct_clamp u_clamp (
    .clk     (clk),
    .rst_n   (rst_n),
    .pct_raw (rate_pct),
    .pct_eff (pct_eff)
  );

  for (genvar r = 0; r < NREG; r++) begin : g_region
    assign acc_sel[r] = acc_vld && (acc_rid == RID_W'(r));
    assign wb_sel[r]  = wb_vld  && (wb_rid  == RID_W'(r));

    wbad_region #(
      .CNT_W      (CNT_W),
      .PERIOD_LEN (PERIOD_LEN)
    ) u_reg (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode      (mode_e),
      .acc_hit   (acc_sel[r]),
      .wb_hit    (wb_sel[r]),
      .slice_end (slice_end),
      .cum_thr   (cum_thresh),
      .pct       (pct_eff),
      .remap_o   (remap_req[r])
    );
  end

  p_sel_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(acc_sel) && $onehot0(wb_sel));

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |=> (remap_req == '0));

endmodule

// File: tb/sim_wb_attack_detector.sv
`timescale 1ns/100ps
module sim_wb_attack_detector;

  localparam int NREG = 4;
  localparam int CNT_W = 8;
  localparam int PLEN = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [1:0]       mode = 2'd0;
  logic [CNT_W-1:0] cum_thresh = 8'd3;
  logic [6:0]       rate_pct = 7'd30;
  logic             acc_vld = 1'b0;
  logic [1:0]       acc_rid = 2'd0;
  logic             wb_vld = 1'b0;
  logic [1:0]       wb_rid = 2'd0;
  logic             slice_end = 1'b0;
  logic [NREG-1:0]  remap_req;

  int n_checks = 0;
  int n_fail = 0;
  logic finished = 1'b0;
  logic [NREG-1:0] got;

  always #2.5 clk = ~clk;

  wb_attack_detector #(.NREG(NREG), .CNT_W(CNT_W), .PERIOD_LEN(PLEN)) u0 (
    .clk(clk), .rst_n(rst_n), .mode(mode), .cum_thresh(cum_thresh),
    .rate_pct(rate_pct), .acc_vld(acc_vld), .acc_rid(acc_rid),
    .wb_vld(wb_vld), .wb_rid(wb_rid), .slice_end(slice_end),
    .remap_req(remap_req)
  );

  typedef struct packed {
    logic [1:0] md;
    logic       av;
    logic [1:0] ar;
    logic       wv;
    logic [1:0] wr;
    logic       se;
    logic [3:0] ex;
  } vec_t;

  // cum_thresh = 3, rate_pct = 30
  localparam vec_t VEC [13] = '{
    '{2'd0, 1'b0, 2'd0, 1'b1, 2'd1, 1'b0, 4'b0000},
    '{2'd0, 1'b1, 2'd2, 1'b1, 2'd1, 1'b0, 4'b0000},
    '{2'd0, 1'b0, 2'd0, 1'b1, 2'd2, 1'b0, 4'b0000},
    '{2'd0, 1'b0, 2'd0, 1'b1, 2'd1, 1'b0, 4'b0010},
    '{2'd0, 1'b0, 2'd0, 1'b0, 2'd0, 1'b0, 4'b0000},
    '{2'd0, 1'b0, 2'd0, 1'b1, 2'd1, 1'b0, 4'b0000},
    '{2'd0, 1'b0, 2'd0, 1'b1, 2'd2, 1'b0, 4'b0000},
    '{2'd0, 1'b0, 2'd0, 1'b1, 2'd2, 1'b0, 4'b0100},
    '{2'd2, 1'b1, 2'd0, 1'b1, 2'd0, 1'b0, 4'b0000},
    '{2'd2, 1'b1, 2'd0, 1'b0, 2'd0, 1'b0, 4'b0000},
    '{2'd2, 1'b1, 2'd3, 1'b0, 2'd0, 1'b0, 4'b0000},
    '{2'd2, 1'b0, 2'd0, 1'b0, 2'd0, 1'b1, 4'b0001},
    '{2'd2, 1'b0, 2'd0, 1'b0, 2'd0, 1'b0, 4'b0000}
  };

  task automatic check(input string tag, input logic [NREG-1:0] act,
                       input logic [NREG-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: remap_req got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic step(input logic [1:0] md, input logic av, input logic [1:0] ar,
                      input logic wv, input logic [1:0] wr, input logic se);
    @(negedge clk);
    mode = md; acc_vld = av; acc_rid = ar; wb_vld = wv; wb_rid = wr; slice_end = se;
    @(posedge clk);
    #1;
    got = remap_req;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; acc_vld = 1'b0; wb_vld = 1'b0; slice_end = 1'b0;
    @(posedge clk); #1;
    check("R1", remap_req, 4'b0000);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1", remap_req, 4'b0000);
  endtask

  initial begin
    do_reset();

    // Vector table: cumulative then time-slice mode
    cum_thresh = 8'd3;
    rate_pct = 7'd30;
    for (int i = 0; i < 13; i++) begin
      step(VEC[i].md, VEC[i].av, VEC[i].ar, VEC[i].wv, VEC[i].wr, VEC[i].se);
      // R2 R4 R5 R7 R9 R11 covered by table rows
      check($sformatf("R2/R4/R5/R7/R9/R11 row %0d", i), got, VEC[i].ex);
    end

    // R3: access window of 16 at 50%, 8 write-backs -> fire on 16th access
    do_reset();
    rate_pct = 7'd50;
    for (int i = 0; i < 8; i++) step(2'd1, 1'b0, 2'd0, 1'b1, 2'd2, 1'b0);
    for (int i = 0; i < PLEN - 1; i++) begin
      step(2'd1, 1'b1, 2'd2, 1'b0, 2'd0, 1'b0);
      if (i == PLEN - 2) check("R3 before close", got, 4'b0000);
    end
    step(2'd1, 1'b1, 2'd2, 1'b0, 2'd0, 1'b0);
    check("R3 close", got, 4'b0100);

    // R10: 7 of 16 misses, window still clears, next 8 of 16 fires
    for (int i = 0; i < 7; i++) step(2'd1, 1'b0, 2'd0, 1'b1, 2'd2, 1'b0);
    for (int i = 0; i < PLEN; i++) step(2'd1, 1'b1, 2'd2, 1'b0, 2'd0, 1'b0);
    check("R10 miss", got, 4'b0000);
    for (int i = 0; i < 8; i++) step(2'd1, 1'b0, 2'd0, 1'b1, 2'd2, 1'b0);
    for (int i = 0; i < PLEN - 1; i++) step(2'd1, 1'b1, 2'd2, 1'b0, 2'd0, 1'b0);
    check("R10 not early", got, 4'b0000);
    step(2'd1, 1'b1, 2'd2, 1'b0, 2'd0, 1'b0);
    check("R10 fresh window", got, 4'b0100);

    // R4: slice_end ignored in access-window mode
    step(2'd1, 1'b1, 2'd0, 1'b1, 2'd0, 1'b0);
    step(2'd1, 1'b0, 2'd0, 1'b0, 2'd0, 1'b1);
    check("R4 slice ignored", got, 4'b0000);

    // R6: low clamp, 1 wb / 6 acc (16.7%) below 20 -> no fire though pct=5
    do_reset();
    rate_pct = 7'd5;
    step(2'd2, 1'b0, 2'd0, 1'b1, 2'd0, 1'b0);
    for (int i = 0; i < 6; i++) step(2'd2, 1'b1, 2'd0, 1'b0, 2'd0, 1'b0);
    step(2'd2, 1'b0, 2'd0, 1'b0, 2'd0, 1'b1);
    check("R6 floor", got, 4'b0000);
    // R6: exactly 20% with 1 wb / 5 acc fires
    step(2'd2, 1'b0, 2'd0, 1'b1, 2'd1, 1'b0);
    for (int i = 0; i < 5; i++) step(2'd2, 1'b1, 2'd1, 1'b0, 2'd0, 1'b0);
    step(2'd2, 1'b0, 2'd0, 1'b0, 2'd0, 1'b1);
    check("R6 floor equal", got, 4'b0010);
    // R6: high clamp, pct=120 acts as 100, 4 wb / 4 acc fires
    rate_pct = 7'd120;
    for (int i = 0; i < 4; i++) step(2'd2, 1'b1, 2'd0, 1'b1, 2'd0, 1'b0);
    step(2'd2, 1'b0, 2'd0, 1'b0, 2'd0, 1'b1);
    check("R6 ceiling", got, 4'b0001);

    // R5: write-backs with no accesses never fire
    rate_pct = 7'd20;
    for (int i = 0; i < 3; i++) step(2'd2, 1'b0, 2'd0, 1'b1, 2'd3, 1'b0);
    step(2'd2, 1'b0, 2'd0, 1'b0, 2'd0, 1'b1);
    check("R5 zero access", got, 4'b0000);

    // R8: saturate both counts, extra write-backs must not wrap
    do_reset();
    rate_pct = 7'd100;
    for (int i = 0; i < 255; i++) step(2'd2, 1'b1, 2'd3, 1'b1, 2'd3, 1'b0);
    for (int i = 0; i < 45; i++) step(2'd2, 1'b0, 2'd0, 1'b1, 2'd3, 1'b0);
    check("R8 quiet before close", got, 4'b0000);
    step(2'd2, 1'b0, 2'd0, 1'b0, 2'd0, 1'b1);
    check("R8 saturated", got, 4'b1000);

    // R9: same-region access and write-back together in cumulative mode
    do_reset();
    cum_thresh = 8'd2;
    step(2'd0, 1'b1, 2'd1, 1'b1, 2'd1, 1'b0);
    check("R9 first", got, 4'b0000);
    step(2'd3, 1'b1, 2'd1, 1'b1, 2'd1, 1'b0);
    check("R9 second", got, 4'b0010);
    step(2'd0, 1'b0, 2'd0, 1'b0, 2'd0, 1'b0);
    check("R7 single pulse", got, 4'b0000);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #500000;
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule